// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small stored-program processor built around one 16-bit accumulator. Code and data share a 256-word by 16-bit memory inside the core. Every instruction word holds an operation code in its upper byte and a memory address or operand in its lower byte. After reset the core fetches from address 0. It then runs instructions one at a time through a multi-cycle control sequencer. When it reaches the halt instruction it stops and raises a flag.

A test port gives access to the memory from outside. The port can write words only while reset is held, so a program and its data are placed before the run starts. The port can read any word at any time, so results can be collected after the halt. The accumulator and the program counter are also brought out for observation.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter and the accumulator become 0 and `halted` is low. After `rst` falls, execution starts with the word at address 0.
- R2: An instruction word has its operation code in bits 15:8 and its address X in bits 7:0. Codes 0x00 and 0x0F to 0xFF are no-operations: the accumulator is unchanged and execution moves to the next word.
- R3: 0x01, 0x02, 0x03 and 0x04 set the accumulator to ACC+mem[X], ACC-mem[X], ACC AND mem[X] and ACC OR mem[X]. Sums and differences wrap modulo 2^16.
- R4: 0x05 sets the accumulator to the bitwise complement of mem[X].
- R5: 0x06 shifts the accumulator right by one bit and 0x07 shifts it left by one bit. Both fill with zero, and the address field is ignored.
- R6: 0x08 sets the accumulator to the low 16 bits of the unsigned product ACC*mem[X]. 0x09 sets it to the unsigned integer quotient ACC/mem[X].
- R7: 0x09 with mem[X]=0 leaves the accumulator unchanged.
- R8: 0x0A loads X into the program counter when accumulator bit 15 is 0. Otherwise execution continues at the next word.
- R9: 0x0B always loads X into the program counter.
- R10: 0x0D writes the accumulator to mem[X]. 0x0E loads mem[X] into the accumulator.
- R11: 0x0C raises `halted`. After that, `halted`, the program counter and the accumulator keep their values until reset. The program counter then points one past the halt word.
- R12: `dbg_we` writes `dbg_wdata` to mem[`dbg_addr`] only while `rst` is high and is ignored otherwise. `dbg_rdata` always shows mem[`dbg_addr`] combinationally.
- R13: A countdown loop that adds 100 down to 1 halts with 5050 in the accumulator and in its result word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_we | input | 1 | Test-port write enable, honoured only in reset |
| dbg_addr | input | 8 | Test-port word address |
| dbg_wdata | input | 16 | Test-port write data |
| dbg_rdata | output | 16 | Test-port read data, combinational |
| halted | output | 1 | High once the halt instruction has executed |
| acc_out | output | 16 | Accumulator value |
| pc_out | output | 8 | Program counter value |

## Verification
The core's store write and the test port's read of the same word can fall in the same cycle. To provoke this, the bench keeps the test port pointed at a store target for the whole run. It samples the read data between edges on every cycle and requires that the first change seen is exactly the value stored there. It must never show an intermediate or partial value. After the halt, a write attempted through the test port outside reset must leave the stored word unchanged.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam logic [7:0] OP_ADD  = 8'h01;
  localparam logic [7:0] OP_SUB  = 8'h02;
  localparam logic [7:0] OP_AND  = 8'h03;
  localparam logic [7:0] OP_OR   = 8'h04;
  localparam logic [7:0] OP_NOT  = 8'h05;
  localparam logic [7:0] OP_SHR  = 8'h06;
  localparam logic [7:0] OP_SHL  = 8'h07;
  localparam logic [7:0] OP_MPY  = 8'h08;
  localparam logic [7:0] OP_DIV  = 8'h09;
  localparam logic [7:0] OP_JGEZ = 8'h0A;
  localparam logic [7:0] OP_JMP  = 8'h0B;
  localparam logic [7:0] OP_HALT = 8'h0C;
  localparam logic [7:0] OP_STO  = 8'h0D;
  localparam logic [7:0] OP_LDA  = 8'h0E;

  typedef enum logic [3:0] {
    ST_FETCH, ST_IREAD, ST_DECODE, ST_OPREAD, ST_OPLATCH,
    ST_EXEC, ST_BRANCH, ST_STAGE, ST_WRITE, ST_HALT
  } seq_state_t;

  typedef struct packed {
    logic mar_from_pc;
    logic mbr_from_mem;
    logic decode;
    logic br_from_mbr;
    logic acc_from_alu;
    logic acc_from_br;
    logic pc_branch;
    logic mbr_from_acc;
    logic mem_write;
  } ctrl_t;

  function automatic logic needs_operand(input logic [7:0] op);
    return (op >= OP_ADD && op <= OP_NOT) || op == OP_MPY ||
           op == OP_DIV || op == OP_LDA;
  endfunction

endpackage

// File: rtl/cpu_mem.sv
module cpu_mem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic [AW-1:0] core_addr,
  output logic [DW-1:0] core_rdata,
  input  logic [AW-1:0] peek_addr,
  output logic [DW-1:0] peek_rdata,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_addr] <= wr_data;
  end

  assign core_rdata = store_q[core_addr];
  assign peek_rdata = store_q[peek_addr];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
  parameter int DW = 16
) (
  input  logic [7:0]    op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] result,
  output logic          div_by_zero
);
  function automatic logic [DW-1:0] f_product(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [2*DW-1:0] full;
    full = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    return full[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] f_quotient(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (b == '0) ? a : a / b;
  endfunction

  always_comb begin
    unique case (op)
      cpu_pkg::OP_ADD: result = acc + opnd;
      cpu_pkg::OP_SUB: result = acc - opnd;
      cpu_pkg::OP_AND: result = acc & opnd;
      cpu_pkg::OP_OR:  result = acc | opnd;
      cpu_pkg::OP_NOT: result = ~opnd;
      cpu_pkg::OP_SHR: result = acc >> 1;
      cpu_pkg::OP_SHL: result = acc << 1;
      cpu_pkg::OP_MPY: result = f_product(acc, opnd);
      cpu_pkg::OP_DIV: result = f_quotient(acc, opnd);
      default:         result = acc;
    endcase
  end

  assign div_by_zero = (op == cpu_pkg::OP_DIV) && (opnd == '0);
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] fetched_op,
  input  logic [7:0] ir,
  input  logic       acc_neg,
  output ctrl_t      ctl,
  output seq_state_t state,
  output logic       take_branch
);
  seq_state_t nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end

  assign take_branch = (state == ST_BRANCH) &&
                       ((ir == OP_JMP) || (ir == OP_JGEZ && !acc_neg));

  always_comb begin
    ctl = '0;
    nxt = state;
    unique case (state)
      ST_FETCH: begin
        ctl.mar_from_pc = 1'b1;
        nxt = ST_IREAD;
      end
      ST_IREAD: begin
        ctl.mbr_from_mem = 1'b1;
        nxt = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.decode = 1'b1;
        if (needs_operand(fetched_op))                         nxt = ST_OPREAD;
        else if (fetched_op == OP_SHR || fetched_op == OP_SHL) nxt = ST_EXEC;
        else if (fetched_op == OP_JMP || fetched_op == OP_JGEZ) nxt = ST_BRANCH;
        else if (fetched_op == OP_STO)                         nxt = ST_STAGE;
        else if (fetched_op == OP_HALT)                        nxt = ST_HALT;
        else                                                   nxt = ST_FETCH;
      end
      ST_OPREAD: begin
        ctl.mbr_from_mem = 1'b1;
        nxt = ST_OPLATCH;
      end
      ST_OPLATCH: begin
        ctl.br_from_mbr = 1'b1;
        nxt = ST_EXEC;
      end
      ST_EXEC: begin
        if (ir == OP_LDA) ctl.acc_from_br  = 1'b1;
        else              ctl.acc_from_alu = 1'b1;
        nxt = ST_FETCH;
      end
      ST_BRANCH: begin
        ctl.pc_branch = take_branch;
        nxt = ST_FETCH;
      end
      ST_STAGE: begin
        ctl.mbr_from_acc = 1'b1;
        nxt = ST_WRITE;
      end
      ST_WRITE: begin
        ctl.mem_write = 1'b1;
        nxt = ST_FETCH;
      end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata,
  output logic          halted,
  output logic [DW-1:0] acc_out,
  output logic [AW-1:0] pc_out
);
  import cpu_pkg::*;
  localparam int OPW = DW - AW;

  logic [AW-1:0]  pc_q, mar_q;
  logic [OPW-1:0] ir_q;
  logic [DW-1:0]  mbr_q, br_q, acc_q;
  logic [DW-1:0]  mem_rdata, alu_res;
  logic           alu_div0, take_branch;
  ctrl_t          ctl;
  seq_state_t     state;

  // named internal events for the checker
  logic evt_decode, evt_jump, evt_div0, evt_core_we;
  assign evt_decode  = ctl.decode;
  assign evt_jump    = ctl.pc_branch;
  assign evt_div0    = ctl.acc_from_alu && alu_div0;
  assign evt_core_we = ctl.mem_write;

  logic          mem_we;
  logic [AW-1:0] mem_wa;
  logic [DW-1:0] mem_wd;
  assign mem_we = ctl.mem_write || (rst && dbg_we);
  assign mem_wa = ctl.mem_write ? mar_q : dbg_addr;
  assign mem_wd = ctl.mem_write ? mbr_q : dbg_wdata;

  cpu_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .core_addr(mar_q), .core_rdata(mem_rdata),
    .peek_addr(dbg_addr), .peek_rdata(dbg_rdata),
    .wr_en(mem_we), .wr_addr(mem_wa), .wr_data(mem_wd)
  );

  cpu_alu #(.DW(DW)) u_alu (
    .op(ir_q), .acc(acc_q), .opnd(br_q),
    .result(alu_res), .div_by_zero(alu_div0)
  );

  cpu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .fetched_op(mbr_q[DW-1:AW]), .ir(ir_q),
    .acc_neg(acc_q[DW-1]), .ctl(ctl), .state(state), .take_branch(take_branch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      mbr_q <= '0;
      br_q  <= '0;
      acc_q <= '0;
    end else begin
      if (ctl.mar_from_pc)  mar_q <= pc_q;
      if (ctl.mbr_from_mem) mbr_q <= mem_rdata;
      if (ctl.mbr_from_acc) mbr_q <= acc_q;
      if (ctl.decode) begin
        ir_q  <= mbr_q[DW-1:AW];
        mar_q <= mbr_q[AW-1:0];
        pc_q  <= pc_q + 1'b1;
      end
      if (ctl.pc_branch)   pc_q <= mar_q;
      if (ctl.br_from_mbr) br_q <= mbr_q;
      if (ctl.acc_from_br) acc_q <= br_q;
      if (ctl.acc_from_alu && !alu_div0) acc_q <= alu_res;
    end
  end

  assign halted  = (state == ST_HALT);
  assign acc_out = acc_q;
  assign pc_out  = pc_q;
endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          halted,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] mar_q,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] mbr_q,
  input logic          evt_decode,
  input logic          evt_jump,
  input logic          evt_div0,
  input logic          evt_core_we
);
  // R1: first cycle out of reset begins at address 0 with a clear accumulator
  a_r1_reset_start: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_q == '0 && acc_q == '0 && !halted));

  // R2: each decode advances the program counter by one word
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    evt_decode |=> pc_q == AW'($past(pc_q) + 1'b1));

  // R7: a division by zero keeps the accumulator
  a_r7_div0_keep: assert property (@(posedge clk) disable iff (rst)
    evt_div0 |=> $stable(acc_q));

  // R8: a taken jump lands on the decoded address
  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    evt_jump |=> pc_q == $past(mar_q));

  // R10: the word written by a store equals the accumulator
  a_r10_store_data: assert property (@(posedge clk) disable iff (rst)
    evt_core_we |-> mbr_q == acc_q);

  // R11: halt is sticky and freezes architectural state
  a_r11_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc_q) && $stable(acc_q)));
endmodule

bind acc_cpu_core acc_cpu_core_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .halted(halted), .pc_q(pc_q), .mar_q(mar_q),
  .acc_q(acc_q), .mbr_q(mbr_q), .evt_decode(evt_decode), .evt_jump(evt_jump),
  .evt_div0(evt_div0), .evt_core_we(evt_core_we)
);

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_we = 1'b0;
  logic [7:0]  dbg_addr = '0;
  logic [15:0] dbg_wdata = '0;
  logic [15:0] dbg_rdata;
  logic        halted;
  logic [15:0] acc_out;
  logic [7:0]  pc_out;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [7:0]  addr;
    logic [15:0] value;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  acc_cpu_core i_acc_cpu_core (
    .clk(clk), .rst(rst), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .halted(halted),
    .acc_out(acc_out), .pc_out(pc_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] w(input logic [7:0] op, input logic [7:0] x);
    return {op, x};
  endfunction

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    dbg_addr = a; dbg_wdata = d; dbg_we = 1'b1;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) poke(8'(a), 16'h0000);
  endtask

  // driver side: queue what memory must hold when the program halts
  task automatic expect_word(input logic [7:0] a, input logic [15:0] v, input string tag);
    exp_t e;
    e.addr = a; e.value = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic run_until_halt(input int limit);
    int n = 0;
    @(negedge clk);
    rst = 1'b0;
    while (!halted && n < limit) begin
      @(negedge clk);
      n++;
    end
    check("watchdog halted", {31'd0, halted}, 32'd1);
  endtask

  // monitor side: pop and compare each expected word
  task automatic drain_scoreboard();
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      dbg_addr = e.addr;
      #1;
      check(e.tag, {16'd0, dbg_rdata}, {16'd0, e.value});
    end
  endtask

  logic [15:0] first_seen;
  logic        seen_change;
  logic        watch_on = 1'b0;
  always @(negedge clk) begin
    if (watch_on && !seen_change && dbg_rdata !== 16'h0000) begin
      seen_change <= 1'b1;
      first_seen  <= dbg_rdata;
    end
  end

  initial begin
    // reset state, R1
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pc in reset", {24'd0, pc_out}, 32'd0);
    check("R1 acc in reset", {16'd0, acc_out}, 32'd0);
    check("R1 halted low in reset", {31'd0, halted}, 32'd0);

    // program A: mixed operations
    clear_mem();
    poke(8'hA0, 16'd12);   poke(8'hA1, 16'd3);   poke(8'hA2, 16'd0);
    poke(8'hA3, 16'h8001); poke(8'hA4, 16'hF0F0); poke(8'hA5, 16'h0FF0);
    poke(8'h00, w(8'h0E, 8'hA0)); poke(8'h01, w(8'h08, 8'hA1)); poke(8'h02, w(8'h0D, 8'hC0));
    poke(8'h03, w(8'h0E, 8'hA0)); poke(8'h04, w(8'h09, 8'hA1)); poke(8'h05, w(8'h0D, 8'hC1));
    poke(8'h06, w(8'h0E, 8'hA0)); poke(8'h07, w(8'h09, 8'hA2)); poke(8'h08, w(8'h0D, 8'hC2));
    poke(8'h09, w(8'h0E, 8'hA4)); poke(8'h0A, w(8'h01, 8'hA5)); poke(8'h0B, w(8'h0D, 8'hC3));
    poke(8'h0C, w(8'h0E, 8'hA5)); poke(8'h0D, w(8'h02, 8'hA4)); poke(8'h0E, w(8'h0D, 8'hC4));
    poke(8'h0F, w(8'h0E, 8'hA4)); poke(8'h10, w(8'h03, 8'hA5)); poke(8'h11, w(8'h0D, 8'hC5));
    poke(8'h12, w(8'h0E, 8'hA4)); poke(8'h13, w(8'h04, 8'hA5)); poke(8'h14, w(8'h0D, 8'hC6));
    poke(8'h15, w(8'h05, 8'hA5)); poke(8'h16, w(8'h0D, 8'hC7));
    poke(8'h17, w(8'h0E, 8'hA3)); poke(8'h18, w(8'h06, 8'hFF)); poke(8'h19, w(8'h0D, 8'hC8));
    poke(8'h1A, w(8'h0E, 8'hA3)); poke(8'h1B, w(8'h07, 8'h00)); poke(8'h1C, w(8'h0D, 8'hC9));
    poke(8'h1D, w(8'h0E, 8'hA3)); poke(8'h1E, w(8'h0A, 8'h30)); poke(8'h1F, w(8'h3F, 8'h55));
    poke(8'h20, w(8'h0D, 8'hCA));
    poke(8'h21, w(8'h0E, 8'hA0)); poke(8'h22, w(8'h0A, 8'h28)); poke(8'h23, w(8'h0C, 8'h00));
    poke(8'h28, w(8'h0E, 8'hA1)); poke(8'h29, w(8'h0B, 8'h2C)); poke(8'h2A, w(8'h0E, 8'hA4));
    poke(8'h2B, w(8'h0C, 8'h00));
    poke(8'h2C, w(8'h0D, 8'hCB)); poke(8'h2D, w(8'h08, 8'hA4)); poke(8'h2E, w(8'h0D, 8'hCC));
    poke(8'h2F, w(8'h0C, 8'h00)); poke(8'h30, w(8'h0C, 8'h00));

    expect_word(8'hC0, 16'd36,   "R6 multiply 12*3");
    expect_word(8'hC1, 16'd4,    "R6 divide 12/3");
    expect_word(8'hC2, 16'd12,   "R7 divide by zero keeps acc");
    expect_word(8'hC3, 16'h00E0, "R3 add wraps");
    expect_word(8'hC4, 16'h1F00, "R3 subtract wraps");
    expect_word(8'hC5, 16'h00F0, "R3 and");
    expect_word(8'hC6, 16'hFFF0, "R3 or");
    expect_word(8'hC7, 16'hF00F, "R4 not");
    expect_word(8'hC8, 16'h4000, "R5 shift right zero fill");
    expect_word(8'hC9, 16'h0002, "R5 shift left drops msb");
    expect_word(8'hCA, 16'h8001, "R8 negative falls through, R2 unknown opcode no-op");
    expect_word(8'hCB, 16'd3,    "R9 jump skipped load, R8 taken");
    expect_word(8'hCC, 16'hD2D0, "R6 multiply keeps low bits");
    expect_word(8'hC0, 16'd36,   "R10 store");

    // store versus concurrent read of the same word
    dbg_addr = 8'hC0;
    seen_change = 1'b0;
    watch_on = 1'b1;
    run_until_halt(20000);
    watch_on = 1'b0;
    check("R12 read during store sees change", {31'd0, seen_change}, 32'd1);
    check("R12 first value read is stored word", {16'd0, first_seen}, 32'd36);
    check("R11 pc after halt", {24'd0, pc_out}, 32'h30);
    check("R10 acc at halt", {16'd0, acc_out}, 32'hD2D0);
    drain_scoreboard();

    // halt freeze, R11
    repeat (20) @(negedge clk);
    check("R11 still halted", {31'd0, halted}, 32'd1);
    check("R11 pc frozen", {24'd0, pc_out}, 32'h30);
    check("R11 acc frozen", {16'd0, acc_out}, 32'hD2D0);

    // write outside reset is ignored, R12
    poke(8'hC0, 16'hDEAD);
    dbg_addr = 8'hC0;
    #1;
    check("R12 write outside reset ignored", {16'd0, dbg_rdata}, 32'd36);

    // program B: sum 100 down to 1, R13
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears acc after run", {16'd0, acc_out}, 32'd0);
    check("R1 reset clears pc after run", {24'd0, pc_out}, 32'd0);
    clear_mem();
    poke(8'h80, 16'd100); poke(8'h81, 16'd0); poke(8'h82, 16'd1);
    poke(8'h00, w(8'h0E, 8'h81)); poke(8'h01, w(8'h01, 8'h80)); poke(8'h02, w(8'h0D, 8'h81));
    poke(8'h03, w(8'h0E, 8'h80)); poke(8'h04, w(8'h02, 8'h82)); poke(8'h05, w(8'h0D, 8'h80));
    poke(8'h06, w(8'h02, 8'h82)); poke(8'h07, w(8'h0A, 8'h00)); poke(8'h08, w(8'h0E, 8'h81));
    poke(8'h09, w(8'h0C, 8'h00));
    expect_word(8'h81, 16'd5050, "R13 sum word");
    expect_word(8'h80, 16'd0,    "R13 counter ends at zero");
    run_until_halt(40000);
    check("R13 acc holds sum", {16'd0, acc_out}, 32'd5050);
    check("R11 pc one past halt", {24'd0, pc_out}, 32'h0A);
    drain_scoreboard();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20ms;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule